// File: doc/BRIEF.md
# Double-Buffered Serial Output Port

This block hands fixed-rate parallel words from an on-chip producer to an external reader that pulls them out serially. The producer clocks its words in on the system clock. The reader supplies its own serial clock and an active-low select, and it reads one bit per clock. Two storage stages sit between them. A holding register takes each new word and raises a ready flag. A separate shift register takes a copy of the held word when the reader starts a transfer. A parallel load that arrives partway through a read therefore lands in the holding register and cannot disturb the bits already going out.

The reader's clock and select are brought into the system clock domain through synchronizer chains, and their edges are detected there. Bits leave most-significant first, in SPI mode 0. Each bit is valid before a rising serial clock edge, and the output moves to the next bit after the falling edge. Two sticky status bits report trouble. One marks an overwritten unread word. The other marks a transfer that the reader abandoned before taking every bit. A single clear pulse resets both.

Top module: `piso_dbuf_port`

## Requirements
- R1: While reset is low and right after it is released, `data_ready`, `overrun` and `short_xfer` are 0 and `host_miso` is 0.
- R2: A `load_valid` pulse stores `load_data` in the holding register. `data_ready` is 1 on the next clock.
- R3: A high-to-low change on `host_csn` copies the holding register into the shift register and clears `data_ready`. This happens no more than SYNC_STAGES+1 system clocks after the change.
- R4: During a transfer, bit 7 (the MSB) is on `host_miso` before the first rising `host_sclk` edge. Each falling `host_sclk` edge moves `host_miso` to the next lower bit, so bit 7-k is present before rising edge k (k counted from 0).
- R5: A word loaded while a transfer is running does not change the bits of that transfer. After the transfer, `data_ready` is 1 and the next transfer sends the new word.
- R6: A load while `data_ready` is 1 replaces the unread word and sets `overrun`. That bit stays 1 until a clear.
- R7: A `status_clr` pulse with no coinciding set condition brings `overrun` and `short_xfer` to 0 on the next clock.
- R8: If `host_csn` returns high after fewer than 8 rising `host_sclk` edges, `short_xfer` is set and stays 1 until a clear. A transfer with all 8 edges leaves it 0.
- R9: `host_miso` is 0 whenever `host_csn` has been high long enough to pass the synchronizer, even when the shift register still holds 1 bits.
- R10: A load in the same clock that a transfer starts does not set `overrun`. The old word is shifted, the new word is held, and `data_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | One-clock strobe that loads a parallel word |
| load_data | input | WORD_W | Parallel word from the producer |
| status_clr | input | 1 | Pulse that clears both sticky status bits |
| data_ready | output | 1 | An unread word is waiting in the holding register |
| overrun | output | 1 | Sticky flag: an unread word was overwritten |
| short_xfer | output | 1 | Sticky flag: a transfer ended early |
| host_sclk | input | 1 | Serial clock driven by the reader |
| host_csn | input | 1 | Active-low select driven by the reader |
| host_miso | output | 1 | Serial data to the reader, 0 when not selected |

## Verification
A table of words drives the main path: alternating bits (A5, 5A), all zeros, all ones, and single bits at the MSB and LSB ends. The single-bit words show whether the bit order is correct. The all-ones word also shows whether the output returns to idle while the shift register still holds ones. Some of the table entries stop after 0, 3 or 7 clock pulses. These entries show that the early-end flag depends on the edge count and not on the data. Directed sequences then load a word in the middle of a transfer, overwrite an unread word, and load in exactly the clock in which the select edge is acted on. Together these separate the correct behaviour from overwrite, lost-word and false-overrun faults.

// File: rtl/piso_pkg.sv
package piso_pkg;
   // Level and single-cycle edge pulses of a synchronized external line
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } line_evt_t;
endpackage

// File: rtl/piso_sync_edge.sv
module piso_sync_edge
   import piso_pkg::*;
#(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      async_in,
   output line_evt_t evt_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("piso_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   always_comb begin
      evt_o.level = chain_q[STAGES-1];
      evt_o.rise  = chain_q[STAGES-1] & ~prev_q;
      evt_o.fall  = ~chain_q[STAGES-1] & prev_q;
   end
endmodule

// File: rtl/piso_hold_stage.sv
module piso_hold_stage #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [WORD_W-1:0] load_data,
   input  logic              take,
   input  logic              status_clr,
   output logic [WORD_W-1:0] hold_q,
   output logic              ready_q,
   output logic              ovr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (load_valid) hold_q <= load_data;

         if (load_valid)  ready_q <= 1'b1;
         else if (take)   ready_q <= 1'b0;

         // A word taken in the same cycle is not lost
         if (load_valid && ready_q && !take) ovr_q <= 1'b1;
         else if (status_clr)                ovr_q <= 1'b0;
      end
   end
endmodule

// File: rtl/piso_shift_stage.sv
module piso_shift_stage #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic [WORD_W-1:0] par_in,
   input  logic              status_clr,
   output logic              ser_out,
   output logic              short_q
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;
   logic              tap;

   if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[WORD_W-2:0], 1'b0};
      assign tap     = sh_q[WORD_W-1];
   end else begin : g_lsb
      assign sh_next = {1'b0, sh_q[WORD_W-1:1]};
      assign tap     = sh_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (start) begin
         sh_q     <= par_in;
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (stop) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (sclk_rise && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
         if (sclk_fall)                  sh_q  <= sh_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               short_q <= 1'b0;
      else if (stop && active_q && cnt_q != FULL) short_q <= 1'b1;
      else if (status_clr)                      short_q <= 1'b0;
   end

   assign ser_out = active_q & tap;
endmodule

// File: rtl/piso_dbuf_port.sv
module piso_dbuf_port
   import piso_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [WORD_W-1:0] load_data,
   input  logic              status_clr,
   output logic              data_ready,
   output logic              overrun,
   output logic              short_xfer,
   input  logic              host_sclk,
   input  logic              host_csn,
   output logic              host_miso
);
   if (WORD_W < 2) begin : g_bad_width
      $error("piso_dbuf_port: WORD_W must be at least 2");
   end

   line_evt_t         csn_evt;
   line_evt_t         sclk_evt;
   logic [WORD_W-1:0] hold_w;
   logic              cs_level;
   logic              cs_fall;
   logic              cs_rise;

   piso_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csn_sync (
      .clk(clk), .rst_n(rst_n), .async_in(host_csn), .evt_o(csn_evt)
   );

   piso_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .async_in(host_sclk), .evt_o(sclk_evt)
   );

   assign cs_level = csn_evt.level;
   assign cs_fall  = csn_evt.fall;
   assign cs_rise  = csn_evt.rise;

   piso_hold_stage #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .load_valid(load_valid), .load_data(load_data),
      .take(cs_fall), .status_clr(status_clr),
      .hold_q(hold_w), .ready_q(data_ready), .ovr_q(overrun)
   );

   piso_shift_stage #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(cs_fall), .stop(cs_rise),
      .sclk_rise(sclk_evt.rise), .sclk_fall(sclk_evt.fall),
      .par_in(hold_w), .status_clr(status_clr),
      .ser_out(host_miso), .short_q(short_xfer)
   );
endmodule

// File: rtl/piso_dbuf_port_chk.sv
module piso_dbuf_port_chk (
   input logic clk,
   input logic rst_n,
   input logic load_valid,
   input logic status_clr,
   input logic data_ready,
   input logic overrun,
   input logic short_xfer,
   input logic host_miso,
   input logic cs_level,
   input logic cs_fall,
   input logic cs_rise
);
   a_r2_load_raises_ready: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |=> data_ready);

   a_r3_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall && !load_valid |=> !data_ready);

   a_r6_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid && data_ready && !cs_fall |=> overrun);

   a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !status_clr |=> overrun);

   a_r7_clear_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      status_clr && !load_valid |=> !overrun);

   a_r8_short_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_xfer) |-> $past(cs_rise));

   a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_level && $past(cs_level) |-> !host_miso);

   a_r10_start_load_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid && cs_fall && !overrun |=> !overrun && data_ready);
endmodule

bind piso_dbuf_port piso_dbuf_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .status_clr(status_clr),
   .data_ready(data_ready), .overrun(overrun), .short_xfer(short_xfer),
   .host_miso(host_miso), .cs_level(cs_level), .cs_fall(cs_fall), .cs_rise(cs_rise)
);

// File: tb/piso_dbuf_port_tb_top.sv
module piso_dbuf_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_valid = 1'b0;
   logic [7:0] load_data = '0;
   logic       status_clr = 1'b0;
   logic       host_sclk = 1'b0;
   logic       host_csn = 1'b1;
   logic       data_ready, overrun, short_xfer, host_miso;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   piso_dbuf_port dut_i (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
      .status_clr(status_clr), .data_ready(data_ready), .overrun(overrun),
      .short_xfer(short_xfer), .host_sclk(host_sclk), .host_csn(host_csn),
      .host_miso(host_miso)
   );

   // {word[7:0], rising edges before release[3:0]}
   localparam logic [11:0] VEC [7] = '{
      12'hA58, 12'h008, 12'hFF3, 12'h018, 12'h800, 12'h3C8, 12'h5A7
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] w);
      @(negedge clk); load_valid = 1'b1; load_data = w;
      @(negedge clk); load_valid = 1'b0;
   endtask

   task automatic clr_status();
      @(negedge clk); status_clr = 1'b1;
      @(negedge clk); status_clr = 1'b0;
   endtask

   task automatic select();
      @(negedge clk); host_csn = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic pulses(input int first, input int n, input logic [7:0] w);
      for (int i = first; i < first + n; i++) begin
         chk("R4 serial bit", host_miso, w[7-i]);
         host_sclk = 1'b1; repeat (4) @(negedge clk);
         host_sclk = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   task automatic release_cs();
      host_csn = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values while held and after release
      chk("R1 ready in reset", data_ready, 0);
      chk("R1 miso in reset", host_miso, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready", data_ready, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 short", short_xfer, 0);
      chk("R1 miso", host_miso, 0);

      // Table walk: R2, R3, R4, R8, R9
      foreach (VEC[v]) begin
         logic [7:0] w;
         int         n;
         w = VEC[v][11:4];
         n = int'(VEC[v][3:0]);
         clr_status();
         load(w);
         chk("R2 ready after load", data_ready, 1);
         select();
         chk("R3 ready cleared at select", data_ready, 0);
         pulses(0, n, w);
         release_cs();
         chk("R8 short status", short_xfer, (n < 8) ? 1 : 0);
         chk("R9 idle miso", host_miso, 0);
         chk("R6 no overrun", overrun, 0);
      end

      // R7: both sticky bits clear (short left set by last entry)
      chk("R8 short sticky", short_xfer, 1);
      clr_status();
      chk("R7 short cleared", short_xfer, 0);

      // R5: load mid-transfer does not disturb shifted bits
      load(8'hC3);
      select();
      pulses(0, 3, 8'hC3);
      load(8'h96);
      pulses(3, 5, 8'hC3);
      release_cs();
      chk("R5 ready after mid load", data_ready, 1);
      chk("R5 no overrun", overrun, 0);
      chk("R8 full transfer not short", short_xfer, 0);
      select();
      pulses(0, 8, 8'h96);
      release_cs();

      // R6: overwrite unread word
      load(8'h11);
      load(8'hE7);
      chk("R6 overrun set", overrun, 1);
      repeat (5) @(negedge clk);
      chk("R6 overrun sticky", overrun, 1);
      select();
      pulses(0, 8, 8'hE7);
      release_cs();
      chk("R6 overrun held", overrun, 1);
      clr_status();
      chk("R7 overrun cleared", overrun, 0);

      // R9: ones left in shift register after early release
      load(8'hFF);
      select();
      pulses(0, 1, 8'hFF);
      release_cs();
      chk("R9 miso low with ones stored", host_miso, 0);
      clr_status();

      // R10: load in the same clock that the select edge is acted on
      load(8'h4B);
      select();
      pulses(0, 8, 8'h4B);
      release_cs();
      load(8'h2D);
      @(negedge clk); host_csn = 1'b0;
      @(negedge clk);
      @(negedge clk); load_valid = 1'b1; load_data = 8'h78;
      @(negedge clk); load_valid = 1'b0;
      chk("R10 no overrun", overrun, 0);
      chk("R10 ready kept", data_ready, 1);
      repeat (3) @(negedge clk);
      pulses(0, 8, 8'h2D);
      release_cs();
      select();
      pulses(0, 8, 8'h78);
      release_cs();
      chk("R10 overrun still clear", overrun, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule